// File: doc/BRIEF.md
# Byte Lane Alignment Splitter

This block sits between a core that issues single-byte or 16-bit word accesses and a 16-bit memory built from two byte-wide banks. The low bank stores every even address and the high bank stores every odd address. Each bank holds half of the byte space. For each bus cycle the block drives a byte address whose bit 0 enables the low bank when it is 0. It also drives an active-low high-bank enable. It places write bytes on the correct data lane and collects read bytes from the correct lane.

A word at an odd address straddles two bank words, so the block issues two bus cycles in a fixed order. The first cycle moves the word's low byte through the high lane at the odd address X. The second cycle moves the high byte through the low lane at X+1, which is the next even address. If X is the top of the space, X+1 wraps to address 0. Read bytes are assembled so that the byte from X always ends up in bits 7:0. The parameter `NARROW` builds the variant for an 8-bit data path. In that variant every word becomes two byte cycles, at X and then at X+1, both on bits 7:0.

The request side and the response side are valid/ready streams. A request is accepted only while the block is idle, so back-pressure reaches the core through `req_ready`. Each bus cycle is offered with `bus_valid` and completes on the first clock edge where `bus_ready` is high. The response is offered with `rsp_valid` and is held until `rsp_ready`. `busy` is a plain status pin.

Top module: `lane_splitter`

## Requirements
- R1: A byte access at an even address uses one bus cycle with `bus_addr` equal to the request address (bit 0 = 0) and `bus_bhe_n` = 1. The write byte is on `bus_wdata[7:0]`. The read byte comes from `bus_rdata[7:0]` and is returned zero-extended in `rsp_rdata`.
- R2: A byte access at an odd address uses one bus cycle with bit 0 of `bus_addr` = 1 and `bus_bhe_n` = 0. The write byte is on `bus_wdata[15:8]`. The read byte comes from `bus_rdata[15:8]` and is returned in `rsp_rdata[7:0]` with bits 15:8 zero.
- R3: A word access at an even address uses one bus cycle with `bus_bhe_n` = 0 and `bus_addr` = X. The full word passes unswapped in both directions.
- R4: A word access at an odd address X uses exactly two bus cycles. The first has `bus_addr` = X, `bus_bhe_n` = 0, and the word's low byte on `bus_wdata[15:8]`. The second has `bus_addr` = X+1, `bus_bhe_n` = 1, and the word's high byte on `bus_wdata[7:0]`.
- R5: A read word response holds the byte at X in bits 7:0 and the byte at X+1 in bits 15:8.
- R6: When the second bus cycle of a split access starts at the highest address, it is issued at address 0 without any other change.
- R7: `busy` is 1 from the cycle after a request is accepted until the last bus cycle of that access completes, and 0 otherwise. `bus_valid` rises in the cycle after acceptance.
- R8: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_addr`, `bus_bhe_n`, `bus_write` and `bus_wdata` hold their values.
- R9: `rsp_valid` rises after the last bus cycle completes. It and `rsp_rdata` hold until `rsp_ready` is 1. `req_ready` stays 0 while a response is pending.
- R10: With `NARROW` = 1, `bus_bhe_n` stays 1 and all data uses bits 7:0. A byte uses one cycle at X. A word at any address uses two cycles, at X and then X+1, with the low byte first.
- R11: After reset, `bus_valid`, `rsp_valid` and `busy` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Byte address of the access |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| busy | output | 1 | Bus cycles of an accepted access are still outstanding |
| bus_valid | output | 1 | Bus cycle offered |
| bus_ready | input | 1 | Bus cycle completes on this edge |
| bus_addr | output | ADDR_W | Byte address of the bus cycle; bit 0 low enables the low bank |
| bus_bhe_n | output | 1 | Active-low enable of the high (odd) bank |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from the banks, sampled when the cycle completes |
| rsp_valid | output | 1 | Access complete, response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 16 | Assembled read data, byte at X in bits 7:0 |

## Verification
The assertions assume that the bus side and the response side follow the handshakes. Read data is taken as valid only on an edge where `bus_ready` is high, and `rsp_ready` may be withheld for any time. The address-sequence property assumes that a new request can arrive only through `req_ready`. The stimulus keeps to these rules. It drives each request for exactly one accepted cycle. It holds `bus_ready` low for a chosen number of cycles before each completion and delays `rsp_ready` the same way. It returns read data that is a fixed function of the bus address, so every lane choice is visible in the result.

// File: rtl/lane_pkg.sv
package lane_pkg;

  // Data lane a bus cycle reads from.
  typedef enum logic [1:0] {
    LANE_LO   = 2'd0,
    LANE_HI   = 2'd1,
    LANE_BOTH = 2'd2
  } lane_e;

  // Per-cycle bank control.
  typedef struct packed {
    logic  bhe_n;
    lane_e lane;
  } beat_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT1 = 2'd1,
    ST_BEAT2 = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/lane_planner.sv
module lane_planner
  import lane_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter bit NARROW = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              word,
  input  logic [15:0]       wdata,
  output logic              split,
  output logic [ADDR_W-1:0] addr1,
  output logic [ADDR_W-1:0] addr2,
  output beat_ctl_t         ctl1,
  output beat_ctl_t         ctl2,
  output logic [15:0]       wd1,
  output logic [15:0]       wd2
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // Second cycle always targets the following byte address; wraps at the top.
  assign addr1 = addr;
  assign addr2 = addr + ONE;

  generate
    if (NARROW) begin : g_narrow
      // 8-bit path: every byte on the low lane, words as two byte cycles.
      always_comb begin
        split = word;
        ctl1  = '{bhe_n: 1'b1, lane: LANE_LO};
        ctl2  = '{bhe_n: 1'b1, lane: LANE_LO};
        wd1   = {wdata[7:0], wdata[7:0]};
        wd2   = {wdata[15:8], wdata[15:8]};
      end
    end else begin : g_wide
      logic odd;
      assign odd = addr[0];
      always_comb begin
        split = 1'b0;
        ctl1  = '{bhe_n: 1'b1, lane: LANE_LO};
        ctl2  = '{bhe_n: 1'b1, lane: LANE_LO};
        wd1   = {wdata[7:0], wdata[7:0]};
        wd2   = {wdata[15:8], wdata[15:8]};
        if (!word) begin
          // Byte replicated to both lanes; enables pick the bank.
          ctl1 = odd ? '{bhe_n: 1'b0, lane: LANE_HI}
                     : '{bhe_n: 1'b1, lane: LANE_LO};
        end else if (!odd) begin
          ctl1 = '{bhe_n: 1'b0, lane: LANE_BOTH};
          wd1  = wdata;
        end else begin
          // Misaligned: low byte via high bank, then high byte via low bank.
          split = 1'b1;
          ctl1  = '{bhe_n: 1'b0, lane: LANE_HI};
          ctl2  = '{bhe_n: 1'b1, lane: LANE_LO};
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lane_sequencer.sv
module lane_sequencer
  import lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       split,
  input  logic       bus_ready,
  input  logic       rsp_ready,
  output seq_state_e state,
  output logic       beat_fire,
  output logic       beat_idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (req_fire)  state <= ST_BEAT1;
        ST_BEAT1: if (bus_ready) state <= split ? ST_BEAT2 : ST_RESP;
        ST_BEAT2: if (bus_ready) state <= ST_RESP;
        ST_RESP:  if (rsp_ready) state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end

  assign beat_idx  = (state == ST_BEAT2);
  assign beat_fire = ((state == ST_BEAT1) || (state == ST_BEAT2)) && bus_ready;

endmodule

// File: rtl/lane_assembler.sv
module lane_assembler
  import lane_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        capture,
  input  logic        beat_idx,
  input  lane_e       lane,
  input  logic [15:0] bus_rdata,
  output logic [15:0] rdata
);

  logic [7:0] sel_byte;

  assign sel_byte = (lane == LANE_HI) ? bus_rdata[15:8] : bus_rdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (clear) begin
      rdata <= '0;
    end else if (capture) begin
      if (lane == LANE_BOTH)  rdata <= bus_rdata;
      else if (!beat_idx)     rdata <= {8'h00, sel_byte};
      else                    rdata[15:8] <= sel_byte;
    end
  end

endmodule

// File: rtl/lane_splitter.sv
module lane_splitter
  import lane_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter bit NARROW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_bhe_n,
  output logic              bus_write,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata
);

  seq_state_e        state;
  logic              req_fire, beat_fire, beat_idx, split;
  logic [ADDR_W-1:0] r_addr, a1, a2;
  logic              r_word, r_write;
  logic [15:0]       r_wdata, wd1, wd2;
  beat_ctl_t         ctl1, ctl2, ctl_cur;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_addr  <= '0;
      r_word  <= 1'b0;
      r_write <= 1'b0;
      r_wdata <= '0;
    end else if (req_fire) begin
      r_addr  <= req_addr;
      r_word  <= req_word;
      r_write <= req_write;
      r_wdata <= req_wdata;
    end
  end

  lane_planner #(.ADDR_W(ADDR_W), .NARROW(NARROW)) u_plan (
    .addr (r_addr),
    .word (r_word),
    .wdata(r_wdata),
    .split(split),
    .addr1(a1),
    .addr2(a2),
    .ctl1 (ctl1),
    .ctl2 (ctl2),
    .wd1  (wd1),
    .wd2  (wd2)
  );

  lane_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .split    (split),
    .bus_ready(bus_ready),
    .rsp_ready(rsp_ready),
    .state    (state),
    .beat_fire(beat_fire),
    .beat_idx (beat_idx)
  );

  assign ctl_cur   = beat_idx ? ctl2 : ctl1;
  assign bus_valid = (state == ST_BEAT1) || (state == ST_BEAT2);
  assign busy      = bus_valid;
  assign bus_addr  = beat_idx ? a2 : a1;
  assign bus_bhe_n = ctl_cur.bhe_n;
  assign bus_write = r_write;
  assign bus_wdata = beat_idx ? wd2 : wd1;
  assign rsp_valid = (state == ST_RESP);

  lane_assembler u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (req_fire),
    .capture  (beat_fire),
    .beat_idx (beat_idx),
    .lane     (ctl_cur.lane),
    .bus_rdata(bus_rdata),
    .rdata    (rsp_rdata)
  );

endmodule

// File: rtl/lane_splitter_chk.sv
module lane_splitter_chk #(
  parameter int ADDR_W = 20,
  parameter bit NARROW = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_bhe_n,
  input logic              bus_write,
  input logic [15:0]       bus_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [15:0]       rsp_rdata
);

  logic              seen;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      last_addr <= '0;
    end else if (req_valid && req_ready) begin
      seen <= 1'b0;
    end else if (bus_valid && bus_ready) begin
      seen      <= 1'b1;
      last_addr <= bus_addr;
    end
  end

  p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_bhe_n)
                                   && $stable(bus_write) && $stable(bus_wdata)));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && !busy));

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && bus_valid));

  // R4, R6, R10: a second cycle in one access is at the next byte address.
  p_second_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && seen) |-> (bus_addr == last_addr + ADDR_W'(1)));

  generate
    if (NARROW) begin : g_n
      p_no_high_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_bhe_n);
    end else begin : g_w
      p_odd_high_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[0]) |-> !bus_bhe_n);
    end
  endgenerate

endmodule

bind lane_splitter lane_splitter_chk #(.ADDR_W(ADDR_W), .NARROW(NARROW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_addr (bus_addr),
  .bus_bhe_n(bus_bhe_n),
  .bus_write(bus_write),
  .bus_wdata(bus_wdata),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata)
);

// File: tb/tb_lane_splitter.sv
module tb_lane_splitter;
  localparam int AW = 20;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          vw = 1'b0, vn = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic          word_in = 1'b0, wr_in = 1'b0, bus_ready = 1'b0, rsp_ready = 1'b0;
  logic [15:0]   wd_in = '0, rd_in = '0;
  bit            sel = 1'b0;

  logic          w_rr, w_busy, w_bv, w_bhe, w_bw, w_rv;
  logic [AW-1:0] w_ba;
  logic [15:0]   w_wd, w_rd;
  logic          n_rr, n_busy, n_bv, n_bhe, n_bw, n_rv;
  logic [AW-1:0] n_ba;
  logic [15:0]   n_wd, n_rd;

  lane_splitter #(.ADDR_W(AW), .NARROW(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(vw), .req_ready(w_rr), .req_addr(a_in),
    .req_word(word_in), .req_write(wr_in), .req_wdata(wd_in), .busy(w_busy),
    .bus_valid(w_bv), .bus_ready(bus_ready), .bus_addr(w_ba), .bus_bhe_n(w_bhe),
    .bus_write(w_bw), .bus_wdata(w_wd), .bus_rdata(rd_in), .rsp_valid(w_rv),
    .rsp_ready(rsp_ready), .rsp_rdata(w_rd));

  lane_splitter #(.ADDR_W(AW), .NARROW(1'b1)) dut_n (
    .clk(clk), .rst_n(rst_n), .req_valid(vn), .req_ready(n_rr), .req_addr(a_in),
    .req_word(word_in), .req_write(wr_in), .req_wdata(wd_in), .busy(n_busy),
    .bus_valid(n_bv), .bus_ready(bus_ready), .bus_addr(n_ba), .bus_bhe_n(n_bhe),
    .bus_write(n_bw), .bus_wdata(n_wd), .bus_rdata(rd_in), .rsp_valid(n_rv),
    .rsp_ready(rsp_ready), .rsp_rdata(n_rd));

  logic          o_rr, o_busy, o_bv, o_bhe, o_bw, o_rv;
  logic [AW-1:0] o_ba;
  logic [15:0]   o_wd, o_rd;
  always_comb begin
    o_rr = sel ? n_rr : w_rr;   o_busy = sel ? n_busy : w_busy;
    o_bv = sel ? n_bv : w_bv;   o_bhe  = sel ? n_bhe : w_bhe;
    o_bw = sel ? n_bw : w_bw;   o_rv   = sel ? n_rv : w_rv;
    o_ba = sel ? n_ba : w_ba;   o_wd   = sel ? n_wd : w_wd;
    o_rd = sel ? n_rd : w_rd;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A ^ {a[15:12], 4'h0};
  endfunction

  task automatic access(logic [AW-1:0] a, bit word, bit wr, logic [15:0] wd,
                        int stall, int rstall);
    int            nb;
    logic [AW-1:0] ea [2];
    bit            ebhe [2], lo_en [2], hi_en [2];
    logic [7:0]    elo [2], ehi [2];
    logic [15:0]   erd;
    string         tag;
    ea[0] = a; ea[1] = a + AW'(1);
    elo[0] = wd[7:0]; ehi[0] = wd[7:0]; elo[1] = wd[15:8]; ehi[1] = wd[15:8];
    ebhe[1] = 1'b1; lo_en[1] = 1'b1; hi_en[1] = 1'b0;
    if (sel) begin
      nb = word ? 2 : 1; ebhe[0] = 1'b1; lo_en[0] = 1'b1; hi_en[0] = 1'b0; tag = "R10";
    end else if (!word) begin
      nb = 1; ebhe[0] = !a[0]; lo_en[0] = !a[0]; hi_en[0] = a[0];
      tag = a[0] ? "R2" : "R1";
    end else if (!a[0]) begin
      nb = 1; ebhe[0] = 1'b0; lo_en[0] = 1'b1; hi_en[0] = 1'b1; ehi[0] = wd[15:8];
      tag = "R3";
    end else begin
      nb = 2; ebhe[0] = 1'b0; lo_en[0] = 1'b0; hi_en[0] = 1'b1; tag = "R4";
    end
    if (word && a == TOP) tag = "R6";
    erd = word ? {mem_byte(ea[1]), mem_byte(a)} : {8'h00, mem_byte(a)};

    @(negedge clk);
    chk("R7", "req_ready idle", 32'(o_rr), 32'd1);
    a_in = a; word_in = word; wr_in = wr; wd_in = wd;
    if (sel) vn = 1'b1; else vw = 1'b1;
    @(negedge clk);
    vw = 1'b0; vn = 1'b0;
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s <= stall; s++) begin
        string t2;
        t2 = (s > 0) ? "R8" : tag;
        chk("R7", "busy", 32'(o_busy), 32'd1);
        chk(t2, "bus_valid", 32'(o_bv), 32'd1);
        chk(t2, "bus_addr", 32'(o_ba), 32'(ea[b]));
        chk(t2, "bus_bhe_n", 32'(o_bhe), 32'(ebhe[b]));
        chk(t2, "bus_write", 32'(o_bw), 32'(wr));
        if (wr && lo_en[b]) chk(t2, "wdata lo", 32'(o_wd[7:0]), 32'(elo[b]));
        if (wr && hi_en[b]) chk(t2, "wdata hi", 32'(o_wd[15:8]), 32'(ehi[b]));
        if (s == stall) begin
          bus_ready = 1'b1;
          if (sel) rd_in = {8'hA5, mem_byte(ea[b])};
          else     rd_in = {mem_byte(ea[b] | AW'(1)), mem_byte(ea[b] & ~AW'(1))};
          if (wr) rd_in = 16'h0000;
          @(negedge clk);
          bus_ready = 1'b0;
        end else begin
          @(negedge clk);
        end
      end
    end
    for (int r = 0; r <= rstall; r++) begin
      chk("R9", "rsp_valid", 32'(o_rv), 32'd1);
      chk("R7", "busy after last cycle", 32'(o_busy), 32'd0);
      chk("R9", "req_ready while pending", 32'(o_rr), 32'd0);
      if (!wr) chk((word && !sel) ? "R5" : tag, "rsp_rdata", 32'(o_rd), 32'(erd));
      if (r == rstall) begin
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk("R9", "rsp_valid dropped", 32'(o_rv), 32'd0);
    chk("R7", "bus idle", 32'(o_bv), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "bus_valid", 32'(w_bv), 32'd0);
    chk("R11", "rsp_valid", 32'(w_rv), 32'd0);
    chk("R11", "busy", 32'(w_busy), 32'd0);
    chk("R11", "req_ready", 32'(w_rr), 32'd1);
    chk("R11", "narrow bus_valid", 32'(n_bv), 32'd0);
    chk("R11", "narrow req_ready", 32'(n_rr), 32'd1);

    // Directed corners, wide path
    access(20'h01234, 1'b0, 1'b0, 16'h0000, 0, 0);   // R1 read
    access(20'h01234, 1'b0, 1'b1, 16'h00C3, 0, 0);   // R1 write
    access(20'h01235, 1'b0, 1'b0, 16'h0000, 1, 0);   // R2 read
    access(20'h01235, 1'b0, 1'b1, 16'h007E, 0, 1);   // R2 write
    access(20'h0ABC0, 1'b1, 1'b0, 16'h0000, 0, 2);   // R3 read
    access(20'h0ABC0, 1'b1, 1'b1, 16'hBEEF, 2, 0);   // R3 write
    access(20'h0ABC1, 1'b1, 1'b0, 16'h0000, 0, 0);   // R4/R5 read
    access(20'h0ABC1, 1'b1, 1'b1, 16'h1357, 3, 1);   // R4 write with stalls
    access(TOP,       1'b1, 1'b0, 16'h0000, 1, 0);   // R6 read wrap
    access(TOP,       1'b1, 1'b1, 16'hA55A, 0, 0);   // R6 write wrap
    access(TOP,       1'b0, 1'b0, 16'h0000, 0, 0);   // R2 top byte
    access(20'h00000, 1'b1, 1'b0, 16'h0000, 0, 0);   // R3 bottom

    for (int i = 0; i < 250; i++) begin
      access(AW'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
             int'($urandom % 3), int'($urandom % 3));
    end

    // Narrow variant
    sel = 1'b1;
    access(20'h00100, 1'b0, 1'b0, 16'h0000, 0, 0);
    access(20'h00101, 1'b0, 1'b1, 16'h0042, 0, 0);
    access(20'h00100, 1'b1, 1'b0, 16'h0000, 1, 0);
    access(20'h00101, 1'b1, 1'b1, 16'h9A7C, 0, 1);
    access(TOP,       1'b1, 1'b0, 16'h0000, 0, 0);
    for (int i = 0; i < 60; i++) begin
      access(AW'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
             int'($urandom % 3), int'($urandom % 3));
    end

    summary();
    $finish;
  end

endmodule